// File: doc/BRIEF.md
# Lane-Confined Two-Source Vector Shuffle

This block rearranges the elements of a 256-bit vector. Each destination element is taken from the pair formed by two source vectors (`src_j_i` above `src_k_i`), at a position given by an index held in the matching element of a control vector. Elements can be bytes, halfwords, words or doublewords. Every 128-bit lane is handled on its own: a lane of the result only ever draws from the same lane of the two sources.

The control vector depends on the element size. For bytes it is a separate index operand. For the wider sizes it is the previous destination value. The block reads all operands as one snapshot, so reusing the destination for both indices and the result is safe. A mode bit selects a 256-bit result or a 128-bit result; in 128-bit mode the upper half of the result is zero. The result is registered and appears one cycle after a valid strobe.

Top module: `vec_lane_shuffle`

## Requirements
- R1: `valid_o` is high in the cycle after each cycle with `valid_i` high, and low otherwise; the result registered on that strobe is on `result_o` at the same time.
- R2: While `valid_i` is low, `result_o` keeps its last value, whatever the other inputs do.
- R3: For an element of width W bits, with m = 128/W elements per lane, the index is bits [7:0] of the control element taken modulo 2m; control bits above that have no effect.
- R4: An index below m selects element number index of `src_k_i`; an index of m or more selects element number index−m of `src_j_i`.
- R5: In 256-bit mode (`wide_i`=1), result elements in bits [255:128] take their element only from bits [255:128] of the selected source, and their indices from the upper half of the control vector.
- R6: For bytes the control vector is `idx_vec_i` and `dst_old_i` has no effect; for halfword, word and doubleword the control vector is `dst_old_i` and `idx_vec_i` has no effect.
- R7: In 128-bit mode (`wide_i`=0), `result_o[255:128]` is zero after the strobe.
- R8: `esize_i` encodes the element width: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 doubleword. Element e of a lane occupies bits [e*W +: W] of that lane.
- R9: While `rst_ni` is low, `result_o` is zero and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: capture a shuffle of the present operands |
| esize_i | input | 2 | Element size code |
| wide_i | input | 1 | 1 = 256-bit result, 0 = 128-bit result |
| src_j_i | input | 256 | First source; upper half of each lane's pool |
| src_k_i | input | 256 | Second source; lower half of each lane's pool |
| idx_vec_i | input | 256 | Index vector used for byte elements |
| dst_old_i | input | 256 | Previous destination, index vector for wider elements |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | 256 | Shuffled vector |

## Verification
The case most easily missed from the ports is an upper-lane element whose index points into the upper half of its pool. A design that leaks across lanes, or that drops the lane offset, would return a lower-lane value there. Random operands cannot tell these apart unless the two halves of each source differ. The stimulus therefore uses fully random 256-bit sources at every size in both modes. Half of the vectors also force the control bits above the modulo range high, so that an index reduced the wrong way lands on a different element.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  typedef enum logic [1:0] {
    ESZ_B = 2'b00,
    ESZ_H = 2'b01,
    ESZ_W = 2'b10,
    ESZ_D = 2'b11
  } esize_e;

  localparam int NUM_SIZES = 4;
  localparam int MIN_EW    = 8;
endpackage

// File: rtl/shuf_lane.sv
module shuf_lane
  import shuf_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic [LANE_W-1:0] src_j_i,
  input  logic [LANE_W-1:0] src_k_i,
  input  logic [LANE_W-1:0] ctl_i,
  input  esize_e            esize_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int POOL_W = 2 * LANE_W;

  logic [POOL_W-1:0] pool;
  logic [LANE_W-1:0] res_sz [NUM_SIZES];
  logic              unused_ctl;

  // k occupies the low half so index < m picks from k
  assign pool       = {src_j_i, src_k_i};
  assign unused_ctl = ^ctl_i;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
    localparam int EW = MIN_EW << s;
    localparam int NE = LANE_W / EW;
    localparam int IW = $clog2(2 * NE);
    for (genvar e = 0; e < NE; e++) begin : g_el
      logic [IW-1:0] sel;
      assign sel = ctl_i[e*EW +: IW];  // low bits == index mod 2m
      assign res_sz[s][e*EW +: EW] = pool[int'(sel)*EW +: EW];
    end
  end

  assign res_o = res_sz[esize_i];
endmodule

// File: rtl/vec_lane_shuffle.sv
module vec_lane_shuffle
  import shuf_pkg::*;
#(
  parameter int VLEN   = 256,
  parameter int LANE_W = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      esize_i,
  input  logic            wide_i,
  input  logic [VLEN-1:0] src_j_i,
  input  logic [VLEN-1:0] src_k_i,
  input  logic [VLEN-1:0] idx_vec_i,
  input  logic [VLEN-1:0] dst_old_i,
  output logic            valid_o,
  output logic [VLEN-1:0] result_o
);
  localparam int NLANE = VLEN / LANE_W;

  esize_e          esz;
  logic [VLEN-1:0] ctl;
  logic [VLEN-1:0] lane_res;
  logic [VLEN-1:0] next_res;

  assign esz = esize_e'(esize_i);
  assign ctl = (esz == ESZ_B) ? idx_vec_i : dst_old_i;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    shuf_lane #(.LANE_W(LANE_W)) u_lane (
      .src_j_i (src_j_i[l*LANE_W +: LANE_W]),
      .src_k_i (src_k_i[l*LANE_W +: LANE_W]),
      .ctl_i   (ctl[l*LANE_W +: LANE_W]),
      .esize_i (esz),
      .res_o   (lane_res[l*LANE_W +: LANE_W])
    );
    if (l == 0) begin : g_base
      assign next_res[l*LANE_W +: LANE_W] = lane_res[l*LANE_W +: LANE_W];
    end else begin : g_upper
      assign next_res[l*LANE_W +: LANE_W] =
        wide_i ? lane_res[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_res;
    end
  end
endmodule

// File: rtl/vec_lane_shuffle_chk.sv
module vec_lane_shuffle_chk #(
  parameter int VLEN   = 256,
  parameter int LANE_W = 128
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      esize_i,
  input logic            wide_i,
  input logic [VLEN-1:0] src_j_i,
  input logic [VLEN-1:0] src_k_i,
  input logic [VLEN-1:0] idx_vec_i,
  input logic [VLEN-1:0] dst_old_i,
  input logic            valid_o,
  input logic [VLEN-1:0] result_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R1
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));  // R2
  AST_NARROW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (result_o[VLEN-1:LANE_W] == '0));  // R7
  AST_DW_PICK_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esize_i == 2'b11 && dst_old_i[1:0] == 2'b00)
    |=> (result_o[63:0] == $past(src_k_i[63:0])));  // R4
  AST_DW_UPPER_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i && esize_i == 2'b11 && dst_old_i[LANE_W +: 2] == 2'b11)
    |=> (result_o[LANE_W +: 64] == $past(src_j_i[LANE_W+64 +: 64])));  // R5
  AST_BYTE_IDX_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esize_i == 2'b00 && idx_vec_i[4:0] == 5'd16)
    |=> (result_o[7:0] == $past(src_j_i[7:0])));  // R6
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && result_o == '0));  // R9
endmodule

bind vec_lane_shuffle vec_lane_shuffle_chk #(.VLEN(VLEN), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_vec_lane_shuffle.sv
module sim_vec_lane_shuffle;
  localparam int VLEN = 256;
  localparam int LW   = 128;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [1:0]      esize_i = 2'b00;
  logic            wide_i = 1'b0;
  logic [VLEN-1:0] src_j_i = '0, src_k_i = '0, idx_vec_i = '0, dst_old_i = '0;
  logic            valid_o;
  logic [VLEN-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  vec_lane_shuffle u0 (.*);

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] j, k, ix, dst,
                                            input int esz, input logic wide);
    logic [VLEN-1:0] r = '0;
    logic [VLEN-1:0] c = (esz == 0) ? ix : dst;
    int ew = 8 << esz;
    int m  = LW / ew;
    for (int l = 0; l < (wide ? 2 : 1); l++) begin
      for (int e = 0; e < m; e++) begin
        int base = l * LW;
        int idx = int'(c[base + e*ew +: 8]) % (2 * m);
        logic [63:0] val;
        if (idx < m) val = 64'(k >> (base + idx * ew));
        else         val = 64'(j >> (base + (idx - m) * ew));
        for (int b = 0; b < ew; b++) r[base + e*ew + b] = val[b];
      end
    end
    return r;
  endfunction

  task automatic check(input logic [VLEN-1:0] got, exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic apply(input int esz, input logic wide, input logic hi);
    logic [VLEN-1:0] j = rnd_vec(), k = rnd_vec(), ix = rnd_vec(), dst = rnd_vec();
    logic [VLEN-1:0] exp, held;
    if (hi) begin
      ix  = ix | {(VLEN/8){8'he0}};
      dst = dst | {(VLEN/8){8'hc0}};
    end
    exp = model(j, k, ix, dst, esz, wide);
    @(negedge clk_i);
    src_j_i = j; src_k_i = k; idx_vec_i = ix; dst_old_i = dst;
    esize_i = 2'(esz); wide_i = wide; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(VLEN'(valid_o), VLEN'(1'b1), "R1 valid_o after strobe");
    check(VLEN'(result_o[LW-1:0]), VLEN'(exp[LW-1:0]),
          (esz == 0) ? "R3 R4 R6 R8 byte low lane" : "R3 R4 R6 R8 wide-elem low lane");
    check(VLEN'(result_o[VLEN-1:LW]), VLEN'(exp[VLEN-1:LW]),
          wide ? "R5 upper lane" : "R7 upper half zero");
    held = result_o;
    src_j_i = rnd_vec(); src_k_i = rnd_vec(); idx_vec_i = rnd_vec(); dst_old_i = rnd_vec();
    @(negedge clk_i);
    check(result_o, held, "R2 hold without strobe");
    check(VLEN'(valid_o), '0, "R1 valid_o idle");
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(result_o, '0, "R9 reset result");
    check(VLEN'(valid_o), '0, "R9 reset valid");
    rst_ni = 1'b1;
    for (int esz = 0; esz < 4; esz++)
      for (int w = 0; w < 2; w++)
        for (int n = 0; n < 60; n++)
          apply(esz, w[0], n[0]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule